// File: doc/BRIEF.md
# Eight-Character Display Line Buffer

A small memory-mapped store for one line of text on a character display. A bus master reads or writes 1, 2, 4 or 8 bytes at any byte offset inside an 8-byte window. The bytes of an access land on consecutive buffer entries, counting from the access address and wrapping from the last entry back to entry 0. Access data is little-endian in a 64-bit word.

Each accepted write pulses a refresh strobe and starts a stream of the whole line, entry 0 first, on a valid/ready character port. While that stream runs, the block holds further writes off by dropping `ready_o`. Reads are taken at any time. The first time the display link comes up after reset, the block streams one line of blank characters (0x20). Later link events do not repeat it.

Top module: `char_line_buf`

## Requirements
- R1: After reset all eight entries read as 0x00, `chr_valid_o` is low and, with `link_up_i` low, `ready_o` is high.
- R2: `size_i` code 0, 1, 2 or 3 selects an access of 1, 2, 4 or 8 bytes. A write changes only that many entries and leaves the rest as they were.
- R3: Byte i of an access maps to entry (`addr_i` + i) mod 8, so an access near the end of the window wraps to entry 0.
- R4: Access byte i sits at `wdata_i`/`rdata_o` bits 8i+7:8i, which is little-endian.
- R5: A read taken in one cycle raises `rvalid_o` in the next cycle. `rdata_o` then holds the selected bytes, and every byte beyond the access size reads as zero.
- R6: A write is taken in a cycle where `req_i`, `we_i` and `ready_o` are all high. `refresh_o` is then high for exactly the next cycle, and all eight entries are streamed in order from entry 0, showing the buffer contents as they are after that write.
- R7: While `chr_valid_o` is high and `chr_ready_i` is low, `chr_valid_o` stays high and `chr_data_o` holds its value.
- R8: `ready_o` is low while a line is streaming. A write presented in that time is not taken until the stream has ended.
- R9: The first rise of `link_up_i` after reset streams eight blank characters (0x20) once. Later falls and rises of the link stream nothing.
- R10: A read taken while a line is streaming returns the current buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Byte offset in the window |
| size_i | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| wdata_i | input | 64 | Write data, little-endian |
| ready_o | output | 1 | A write can be taken this cycle |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Read data, zero beyond the access size |
| refresh_o | output | 1 | One-cycle pulse after each accepted write |
| link_up_i | input | 1 | Display link is connected |
| chr_valid_o | output | 1 | Character beat valid |
| chr_data_o | output | 8 | Character code |
| chr_ready_i | input | 1 | Sink accepts the character |

## Verification
The bench builds the block with its default parameters: eight entries of eight bits. With these values the 3-bit address and the 2-bit size code cover every pair of start offset and access width, so the bench reads all 32 of them against its model, including full-window 8-byte accesses that start mid-line and wrap. Three sink ready patterns (always ready, every other cycle, one in four) stretch the streams, so the hold-off of writes, reads during a stream and back-pressure on the character port all come up in one run.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam logic [7:0] BLANK_CHAR = 8'h20;
  typedef enum logic [1:0] {SZ_B1 = 2'd0, SZ_B2 = 2'd1, SZ_B4 = 2'd2, SZ_B8 = 2'd3} acc_size_e;
endpackage

// File: rtl/clb_lane_map.sv
module clb_lane_map #(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter int IDX_W  = $clog2(N),
  parameter int SIZE_W = $clog2(IDX_W + 1)
) (
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [N*W-1:0]    wdata_i,
  input  logic [N*W-1:0]    line_i,
  output logic [N-1:0]      wen_o,
  output logic [N*W-1:0]    wline_o,
  output logic [N*W-1:0]    rdata_o
);
  logic [IDX_W:0] nbytes;
  assign nbytes = (IDX_W+1)'(1) << size_i;

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [IDX_W-1:0] k;  // access byte landing on entry e
    assign k = IDX_W'(e) - addr_i;
    assign wen_o[e] = {1'b0, k} < nbytes;
    assign wline_o[e*W +: W] = wdata_i[k*W +: W];
  end

  for (genvar i = 0; i < N; i++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(i) + addr_i;
    assign rdata_o[i*W +: W] = ((IDX_W+1)'(i) < nbytes) ? line_i[idx*W +: W] : '0;
  end
endmodule

// File: rtl/clb_store.sv
module clb_store #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [N-1:0]   wen_i,
  input  logic [N*W-1:0] wline_i,
  output logic [N*W-1:0] line_o
);
  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                line_o[e*W +: W] <= '0;
      else if (we_i && wen_i[e]) line_o[e*W +: W] <= wline_i[e*W +: W];
    end
  end
endmodule

// File: rtl/clb_streamer.sv
module clb_streamer #(
  parameter int         N     = 8,
  parameter int         W     = 8,
  parameter int         IDX_W = $clog2(N),
  parameter logic [W-1:0] BLANK = W'(8'h20)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           blank_i,
  input  logic [N*W-1:0] line_i,
  output logic           busy_o,
  output logic           valid_o,
  output logic [W-1:0]   data_o,
  input  logic           ready_i
);
  logic             busy_q, blank_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      blank_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        blank_q <= blank_i;
        cnt_q   <= '0;
      end
    end else if (ready_i) begin
      if (cnt_q == IDX_W'(N - 1)) busy_q <= 1'b0;
      else                        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = busy_q;
  assign data_o  = blank_q ? BLANK : line_i[cnt_q*W +: W];
endmodule

// File: rtl/char_line_buf.sv
module char_line_buf #(
  parameter int NUM_CHARS = 8,
  parameter int CHAR_W    = 8,
  localparam int IDX_W    = $clog2(NUM_CHARS),
  localparam int SIZE_W   = $clog2(IDX_W + 1),
  localparam int DATA_W   = NUM_CHARS * CHAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              refresh_o,
  input  logic              link_up_i,
  output logic              chr_valid_o,
  output logic [CHAR_W-1:0] chr_data_o,
  input  logic              chr_ready_i
);
  import clb_pkg::*;

  logic [NUM_CHARS-1:0] wen;
  logic [DATA_W-1:0]    wline, line, rmap;
  logic busy, inited_q, init_need, init_go, wr_acc, rd_acc;

  assign init_need = link_up_i & ~inited_q;
  assign init_go   = init_need & ~busy;
  assign ready_o   = ~busy & ~init_need;  // blank fill wins over a write
  assign wr_acc    = req_i & we_i & ready_o;
  assign rd_acc    = req_i & ~we_i;

  clb_lane_map #(.N(NUM_CHARS), .W(CHAR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_map (
    .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i), .line_i(line),
    .wen_o(wen), .wline_o(wline), .rdata_o(rmap)
  );

  clb_store #(.N(NUM_CHARS), .W(CHAR_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_acc), .wen_i(wen),
    .wline_i(wline), .line_o(line)
  );

  clb_streamer #(.N(NUM_CHARS), .W(CHAR_W), .IDX_W(IDX_W),
                 .BLANK(CHAR_W'(BLANK_CHAR))) u_stream (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(wr_acc | init_go), .blank_i(init_go),
    .line_i(line), .busy_o(busy), .valid_o(chr_valid_o), .data_o(chr_data_o),
    .ready_i(chr_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inited_q  <= 1'b0;
      refresh_o <= 1'b0;
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
    end else begin
      inited_q  <= inited_q | init_go;
      refresh_o <= wr_acc;
      rvalid_o  <= rd_acc;
      if (rd_acc) rdata_o <= rmap;
    end
  end
endmodule

// File: rtl/clb_checker.sv
module clb_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic              refresh_o,
  input logic              chr_valid_o,
  input logic [CHAR_W-1:0] chr_data_o,
  input logic              chr_ready_i
);
  a_r5_rvalid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);
  a_r6_refresh_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |=> !refresh_o);
  a_r6_refresh_streams: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> chr_valid_o);
  a_r7_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o && !chr_ready_i |=> chr_valid_o && $stable(chr_data_o));
  a_r8_no_ready_in_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o |-> !ready_o);
endmodule

bind char_line_buf clb_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .ready_o(ready_o),
  .rvalid_o(rvalid_o), .refresh_o(refresh_o), .chr_valid_o(chr_valid_o),
  .chr_data_o(chr_data_o), .chr_ready_i(chr_ready_i)
);

// File: tb/sim_char_line_buf.sv
`timescale 1ns/1ps
module sim_char_line_buf;
  import clb_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, link = 0, chr_ready = 0;
  logic [2:0] addr = '0;
  logic [1:0] size = '0;
  logic [63:0] wdata = '0;
  logic ready, rvalid, refresh, chr_valid;
  logic [63:0] rdata;
  logic [7:0] chr_data;

  int checks = 0, fails = 0, rmode = 0, cyc = 0;
  logic [7:0] mem [8];
  logic [7:0] expq [$];

  always #4 clk = ~clk;

  char_line_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .refresh_o(refresh), .link_up_i(link), .chr_valid_o(chr_valid),
    .chr_data_o(chr_data), .chr_ready_i(chr_ready)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: beat transfers at the posedge after a negedge that sees valid & ready
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    case (rmode)
      0: chr_ready = 1'b1;
      1: chr_ready = cyc[0];
      default: chr_ready = (cyc % 4 == 0);
    endcase
    @(negedge clk);
    if (rst_n && chr_valid && chr_ready) begin
      if (expq.size() == 0) chk("R6/R9 unexpected beat", {56'h0, chr_data}, 64'hx);
      else chk("R6/R9 beat", {56'h0, chr_data}, {56'h0, expq.pop_front()});
    end
  end

  task automatic do_write(input int a, input acc_size_e sz, input logic [63:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = 3'(a); size = sz; wdata = d;
    while (!ready) @(negedge clk);
    for (int i = 0; i < (1 << sz); i++) mem[(a + i) % 8] = d[8*i +: 8];
    for (int e = 0; e < 8; e++) expq.push_back(mem[e]);
    @(negedge clk);
    req = 0; we = 0;
    chk("R6 refresh pulse", {63'h0, refresh}, 64'h1);
  endtask

  task automatic do_read(input int a, input acc_size_e sz, input string tag);
    logic [63:0] exp;
    @(negedge clk);
    req = 1; we = 0; addr = 3'(a); size = sz;
    @(negedge clk);
    req = 0;
    exp = '0;
    for (int i = 0; i < (1 << sz); i++) exp[8*i +: 8] = mem[(a + i) % 8];
    chk({tag, " rvalid R5"}, {63'h0, rvalid}, 64'h1);
    chk(tag, rdata, exp);
  endtask

  task automatic drain();
    int n = 0;
    while ((expq.size() != 0 || chr_valid) && n < 2000) begin @(negedge clk); n++; end
    chk("R6 stream drained", 64'(expq.size()), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    for (int e = 0; e < 8; e++) mem[e] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 ready after reset", {63'h0, ready}, 64'h1);
    chk("R1 no beat after reset", {63'h0, chr_valid}, 64'h0);
    do_read(0, SZ_B8, "R1 buffer zero");

    // R9 blank fill on first link
    @(negedge clk); link = 1;
    for (int e = 0; e < 8; e++) expq.push_back(BLANK_CHAR);
    @(negedge clk);
    chk("R9 write held during fill", {63'h0, ready}, 64'h0);
    drain();
    @(negedge clk); link = 0;
    repeat (3) @(negedge clk); link = 1;
    seen = 0;
    repeat (30) begin @(negedge clk); if (chr_valid) seen++; end
    chk("R9 fill not repeated", 64'(seen), 64'h0);

    // R4 little-endian full line
    do_write(0, SZ_B8, 64'h4847_4645_4443_4241);
    drain();
    do_read(0, SZ_B8, "R4 full line");
    // R2 single byte leaves others
    rmode = 1;
    do_write(5, SZ_B1, 64'hFFFF_FFFF_FFFF_FF5A);
    drain();
    do_read(0, SZ_B8, "R2 one byte write");
    // R3 wrap cases
    do_write(7, SZ_B2, 64'h1111_1111_1111_BBAA);
    drain();
    do_read(0, SZ_B8, "R3 two byte wrap");
    do_write(6, SZ_B4, 64'h0000_0000_4433_2211);
    drain();
    do_read(7, SZ_B2, "R3 read wrap");
    do_write(3, SZ_B8, 64'h7877_7675_7473_7271);
    drain();
    // R5 every offset and size
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 4; s++) do_read(a, acc_size_e'(s), "R5 read sweep");

    // R8 / R10 with slow sink
    rmode = 2;
    do_write(2, SZ_B2, 64'h0000_0000_0000_6463);
    chk("R8 ready low in stream", {63'h0, ready}, 64'h0);
    do_read(0, SZ_B8, "R10 read during stream");
    do_write(1, SZ_B1, 64'h0000_0000_0000_00E1);
    drain();
    do_read(0, SZ_B8, "R8 held write landed");

    rmode = 0;
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule